// File: doc/BRIEF.md
# Companding Serial Port Data Buffer

This block holds the word buffers of one synchronous serial port with two channels. Each channel has a 32-bit transmit buffer and a 32-bit receive buffer. Software reaches all of them through a simple register port. The serial shifter is outside the block and uses the word ports: it takes transmit words from `tx_a_word` and `tx_b_word`, and it delivers received words with a one-cycle load strobe per channel.

Channel A also has a companding unit that follows G.711, with mu-law and A-law selectable. A register write to the channel A transmit buffer is rewritten one cycle later with the 8-bit compressed code. A register write to the channel A receive buffer is rewritten one cycle later with the expanded linear value. During that cycle `busy` is high. Any register access made during that cycle is stalled, so a read made straight after the write returns the converted value. When companding is off, received words shorter than 32 bits are either zero-filled or sign-extended above the word's MSB. Channel B is never companded.

Top module: `sport_compand_buf`

## Requirements
- R1: After reset the control register reads 0x000000F8 (companding off, zero-fill, word length 32). All four buffers, `tx_a_word`, `tx_b_word`, `busy` and `reg_stall` are zero.
- R2: Addresses are: 0 control, 1 channel A transmit, 2 channel A receive, 3 channel B transmit, 4 channel B receive. Any other address reads zero. A buffer write with no conversion is stored unchanged. After the accepting edge it reads back and appears on the matching transmit word port.
- R3: Control bits [1:0] select the mode: 0 off, 1 mu-law, 2 A-law, 3 off. Bit [2] selects sign extension (1) or zero-fill (0). Bits [7:3] hold the word length minus one, and a value below 2 is treated as 2, giving a 3-bit word. Bits [31:8] read zero.
- R4: In mu-law or A-law mode, an accepted write to address 1 or 2 raises `busy` for exactly the next cycle, and for no other cycle.
- R5: While `busy` is high, a read or write request raises `reg_stall` and is not performed. The requester holds the request. A read held this way returns the converted value.
- R6: Mu-law compression takes the low L bits of the written word, with the sign at bit L-1, scales that sample to 16 bits and encodes it per G.711. The buffer then holds the code in bits [7:0] with bits [31:8] zero. A zero word gives 0xFF.
- R7: A-law compression uses the same sample scaling and G.711 A-law encoding. A zero word gives 0xD5, and bits [31:8] are zero.
- R8: Mu-law expansion decodes bits [7:0] of the written word to a 16-bit G.711 linear value. For L of 16 or more it shifts the value left by L-16. For smaller L it shifts right arithmetically by 16-L. The result is sign-extended to 32 bits.
- R9: A-law expansion decodes to the 16-bit G.711 linear value and scales it to L bits the same way as R8.
- R10: With companding off, a serial load on either channel stores the low L bits of the word. Bits above L-1 are zero-filled, or copy bit L-1 when bit [2] is set.
- R11: In mu-law or A-law mode, a serial load on channel A stores the expansion of the word's bits [7:0]. Channel B loads are only formatted as in R10 and are never expanded.
- R12: On the same buffer in the same cycle, a pending conversion wins over a register write, and a register write wins over a serial load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid when not stalled |
| reg_stall | output | 1 | Request held off; the requester retries next cycle |
| busy | output | 1 | In-place conversion cycle |
| rx_a_load | input | 1 | Channel A received-word strobe |
| rx_a_word | input | 32 | Channel A received word |
| rx_b_load | input | 1 | Channel B received-word strobe |
| rx_b_word | input | 32 | Channel B received word |
| tx_a_word | output | 32 | Channel A transmit buffer contents |
| tx_b_word | output | 32 | Channel B transmit buffer contents |

## Verification
The assertions assume a requester that keeps a stalled request, with the same address and data, until `reg_stall` drops. They also assume that no serial load targets channel B's transmit path, which has no load input. Under these assumptions, a write seen during `busy` can only be a held retry and must leave the buffers alone. The stimulus changes inputs one nanosecond after a rising edge and keeps every request asserted until it reaches a falling edge with no stall. Serial load strobes last exactly one cycle.

// File: rtl/sport_compand_buf.sv
module sport_compand_buf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_stall,
  output logic        busy,
  input  logic        rx_a_load,
  input  logic [31:0] rx_a_word,
  input  logic        rx_b_load,
  input  logic [31:0] rx_b_word,
  output logic [31:0] tx_a_word,
  output logic [31:0] tx_b_word
);
  localparam logic [2:0] AD_CTRL = 3'd0, AD_TXA = 3'd1, AD_RXA = 3'd2,
                         AD_TXB = 3'd3, AD_RXB = 3'd4;

  logic [31:0] ctrl_q, txa_q, rxa_q, txb_q, rxb_q;
  logic        pend_q, pend_rx_q;

  wire       mu_on  = ctrl_q[1:0] == 2'd1;
  wire       al_on  = ctrl_q[1:0] == 2'd2;
  wire       cmp_on = mu_on | al_on;
  wire       sx_on  = ctrl_q[2];
  wire [5:0] wlen   = (ctrl_q[7:3] < 5'd2) ? 6'd3 : {1'b0, ctrl_q[7:3]} + 6'd1;
  wire       wr_ok  = reg_wr & ~pend_q;
  wire       trig   = wr_ok & cmp_on & (reg_addr == AD_TXA || reg_addr == AD_RXA);

  function automatic logic [15:0] to16(logic [31:0] w, logic [5:0] len);
    logic signed [31:0] t;
    t = $signed(w << (6'd32 - len)) >>> (6'd32 - len);
    if (len >= 6'd16) t = t >>> (len - 6'd16);
    else              t = t <<< (6'd16 - len);
    return t[15:0];
  endfunction

  function automatic logic [31:0] from16(logic [15:0] lin, logic [5:0] len);
    logic signed [31:0] t;
    t = $signed({{16{lin[15]}}, lin});
    if (len >= 6'd16) t = t <<< (len - 6'd16);
    else              t = t >>> (6'd16 - len);
    return t;
  endfunction

  function automatic logic [31:0] fmt(logic [31:0] w, logic [5:0] len, logic se);
    logic signed [31:0] t;
    t = $signed(w << (6'd32 - len)) >>> (6'd32 - len);
    return se ? t : (w & (32'hFFFF_FFFF >> (6'd32 - len)));
  endfunction

  function automatic logic [7:0] mu_enc(logic [15:0] s);
    logic [15:0] mag, sh;
    logic [2:0]  ex;
    mag = s[15] ? (~s + 16'd1) : s;
    if (mag > 16'd32635) mag = 16'd32635;
    mag = mag + 16'd132;
    ex = 3'd0;
    for (int i = 1; i < 8; i++) if (mag[i+7]) ex = 3'(i);
    sh = mag >> ({1'b0, ex} + 4'd3);
    return ~{s[15], ex, sh[3:0]};
  endfunction

  function automatic logic [15:0] mu_dec(logic [7:0] c);
    logic [7:0]  u;
    logic [16:0] t;
    u = ~c;
    t = (17'({u[3:0], 3'b000}) + 17'd132) << u[6:4];
    t = t - 17'd132;
    return u[7] ? -t[15:0] : t[15:0];
  endfunction

  function automatic logic [7:0] al_enc(logic [15:0] s);
    logic [15:0] p, sh;
    logic [7:0]  mask;
    logic [2:0]  sg;
    p = 16'($signed(s) >>> 3);
    if (!p[15]) mask = 8'hD5;
    else begin
      mask = 8'h55;
      p    = ~p;
    end
    sg = 3'd7;
    for (int i = 6; i >= 0; i--) if (p < (16'd32 << i)) sg = 3'(i);
    sh = (sg < 3'd2) ? (p >> 1) : (p >> sg);
    return {1'b0, sg, sh[3:0]} ^ mask;
  endfunction

  function automatic logic [15:0] al_dec(logic [7:0] c);
    logic [7:0]  a;
    logic [15:0] t;
    a = c ^ 8'h55;
    t = {8'b0, a[3:0], 4'b0};
    if (a[6:4] == 3'd0) t = t + 16'd8;
    else begin
      t = t + 16'h108;
      if (a[6:4] > 3'd1) t = t << (a[6:4] - 3'd1);
    end
    return a[7] ? t : -t;
  endfunction

  function automatic logic [31:0] expand(logic [7:0] c, logic use_mu, logic [5:0] len);
    return from16(use_mu ? mu_dec(c) : al_dec(c), len);
  endfunction

  wire [15:0]  tx_s16   = to16(txa_q, wlen);
  wire [7:0]   tx_code  = mu_on ? mu_enc(tx_s16) : al_enc(tx_s16);
  wire [31:0]  rx_lin   = expand(rxa_q[7:0], mu_on, wlen);
  wire [31:0]  rxa_in   = cmp_on ? expand(rx_a_word[7:0], mu_on, wlen)
                                 : fmt(rx_a_word, wlen, sx_on);
  wire [31:0]  rxb_in   = fmt(rx_b_word, wlen, sx_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= 32'h0000_00F8;
      txa_q     <= '0;
      rxa_q     <= '0;
      txb_q     <= '0;
      rxb_q     <= '0;
      pend_q    <= 1'b0;
      pend_rx_q <= 1'b0;
    end else begin
      pend_q    <= trig;
      pend_rx_q <= trig & (reg_addr == AD_RXA);

      if (wr_ok && reg_addr == AD_CTRL) ctrl_q <= {24'b0, reg_wdata[7:0]};

      if (pend_q && !pend_rx_q)          txa_q <= {24'b0, tx_code};
      else if (wr_ok && reg_addr == AD_TXA) txa_q <= reg_wdata;

      if (pend_q && pend_rx_q)           rxa_q <= rx_lin;
      else if (wr_ok && reg_addr == AD_RXA) rxa_q <= reg_wdata;
      else if (rx_a_load)                rxa_q <= rxa_in;

      if (wr_ok && reg_addr == AD_TXB)   txb_q <= reg_wdata;

      if (wr_ok && reg_addr == AD_RXB)   rxb_q <= reg_wdata;
      else if (rx_b_load)                rxb_q <= rxb_in;
    end
  end

  always_comb begin
    case (reg_addr)
      AD_CTRL: reg_rdata = ctrl_q;
      AD_TXA:  reg_rdata = txa_q;
      AD_RXA:  reg_rdata = rxa_q;
      AD_TXB:  reg_rdata = txb_q;
      AD_RXB:  reg_rdata = rxb_q;
      default: reg_rdata = '0;
    endcase
  end

  assign busy      = pend_q;
  assign reg_stall = pend_q & (reg_wr | reg_rd);
  assign tx_a_word = txa_q;
  assign tx_b_word = txb_q;
endmodule

module sport_compand_buf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        reg_stall,
  input logic        busy,
  input logic        pend_rx,
  input logic [1:0]  mode,
  input logic [31:0] tx_a_word,
  input logic [31:0] tx_b_word
);
  a_r4_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r4_busy_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && (reg_addr == 3'd1 || reg_addr == 3'd2) &&
     (mode == 2'd1 || mode == 2'd2)) |=> busy);

  a_r5_stall_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stall |-> busy);

  a_r5_stall_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (reg_wr || reg_rd)) |-> reg_stall);

  a_r5_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 3'd3) |=> $stable(tx_b_word));

  a_r2_txb_store: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && reg_addr == 3'd3) |=> tx_b_word == $past(reg_wdata));

  a_r6_code_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pend_rx) |=> tx_a_word[31:8] == 24'd0);
endmodule

bind sport_compand_buf sport_compand_buf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_stall(reg_stall),
  .busy(busy), .pend_rx(pend_rx_q), .mode(ctrl_q[1:0]),
  .tx_a_word(tx_a_word), .tx_b_word(tx_b_word)
);

// File: tb/sport_compand_buf_test.sv
`timescale 1ns/100ps
module sport_compand_buf_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        reg_stall, busy;
  logic        rx_a_load = 0, rx_b_load = 0;
  logic [31:0] rx_a_word = 0, rx_b_word = 0, tx_a_word, tx_b_word;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  sport_compand_buf uut (.*);

  always #2 clk = ~clk;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk)
    if (rst_n && reg_rd && !reg_stall) begin
      logic [31:0] e;
      string t;
      if (exp_q.size() == 0) chk(0, "scoreboard empty", reg_rdata, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(reg_rdata === e, t, reg_rdata, e);
      end
    end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    do @(negedge clk); while (reg_stall);
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, string tg);
    reg_rd = 1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tg);
    do @(negedge clk); while (reg_stall);
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic set_ctrl(int len, int se, int mode);
    wr(3'd0, 32'(((len - 1) << 3) | (se << 2) | mode));
  endtask

  function automatic longint sx(longint w, int len);
    longint v;
    v = w & ((64'sd1 << len) - 1);
    if ((v >> (len - 1)) & 1) v = v - (64'sd1 << len);
    return v;
  endfunction

  function automatic longint s16(longint w, int len);
    longint v;
    v = sx(w, len);
    if (len >= 16) v = v >>> (len - 16); else v = v <<< (16 - len);
    return v;
  endfunction

  function automatic logic [31:0] mu_e(longint s);
    longint m; int sg, e;
    sg = s < 0; m = sg ? -s : s;
    if (m > 32635) m = 32635;
    m += 132;
    e = 7;
    while (e > 0 && !((m >> (e + 7)) & 1)) e--;
    return 32'((~((sg << 7) | (e << 4) | int'((m >> (e + 3)) & 15))) & 255);
  endfunction

  function automatic logic [31:0] a_e(longint s);
    longint p; int mask, seg, av;
    p = s >>> 3;
    if (p >= 0) mask = 'hD5; else begin mask = 'h55; p = -p - 1; end
    seg = 0;
    while (seg < 7 && p > (32 << seg) - 1) seg++;
    av = seg << 4;
    av |= (seg < 2) ? int'((p >> 1) & 15) : int'((p >> seg) & 15);
    return 32'((av ^ mask) & 255);
  endfunction

  function automatic longint mu_d(int c);
    int u; longint t;
    u = ~c & 255;
    t = (longint'(((u & 15) << 3) + 132)) << ((u >> 4) & 7);
    t -= 132;
    return (u & 128) ? -t : t;
  endfunction

  function automatic longint a_d(int c);
    int a, seg; longint t;
    a = c ^ 'h55;
    t = (a & 15) << 4;
    seg = (a >> 4) & 7;
    if (seg == 0) t += 8;
    else begin
      t += 'h108;
      if (seg > 1) t = t << (seg - 1);
    end
    return (a & 128) ? t : -t;
  endfunction

  function automatic logic [31:0] scale(longint lin, int len);
    longint r;
    r = (len >= 16) ? (lin <<< (len - 16)) : (lin >>> (16 - len));
    return 32'(r & 64'hFFFF_FFFF);
  endfunction

  function automatic logic [31:0] fmt(longint w, int len, int se);
    return se ? 32'(sx(w, len) & 64'hFFFF_FFFF) : 32'(w & ((64'sd1 << len) - 1));
  endfunction

  longint vals[6] = '{0, 1000, -1000, 32767, -32768, 5};
  int     codes[5] = '{'h00, 'h7F, 'h80, 'hFF, 'h35};
  int     lens[3]  = '{16, 24, 8};

  initial begin
    #400000;
    chk(0, "watchdog expired", 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    chk(busy === 0 && reg_stall === 0, "R1 busy/stall", {30'b0, busy, reg_stall}, 0);
    chk(tx_a_word === 0 && tx_b_word === 0, "R1 tx words", tx_a_word | tx_b_word, 0);
    rd(0, 32'h0000_00F8, "R1 ctrl");
    for (int a = 1; a < 5; a++) rd(3'(a), 0, "R1 buffer");

    // R3 control fields, mode 3 behaves as off; R2 plain store
    wr(0, 32'hFFFF_FF3B);
    rd(0, 32'h0000_003B, "R3 ctrl readback");
    wr(1, 32'h0000_1234);
    chk(busy === 0, "R3 mode3 no busy", {31'b0, busy}, 0);
    chk(tx_a_word === 32'h1234, "R2 tx_a_word", tx_a_word, 32'h1234);
    rd(1, 32'h0000_1234, "R2 txa store");
    wr(3, 32'hCAFE_0042);
    chk(tx_b_word === 32'hCAFE_0042, "R2 tx_b_word", tx_b_word, 32'hCAFE_0042);
    rd(3, 32'hCAFE_0042, "R2 txb store");
    rd(5, 0, "R2 unmapped");
    rd(7, 0, "R2 unmapped");

    // R6 mu-law compression, R4 busy, R5 stall on read
    set_ctrl(16, 0, 1);
    wr(1, 0);
    chk(busy === 1, "R4 busy after write", {31'b0, busy}, 1);
    reg_rd = 1; reg_addr = 1; #0.5;
    chk(reg_stall === 1, "R5 read stalled", {31'b0, reg_stall}, 1);
    rd(1, 32'h0000_00FF, "R6 mu zero");
    chk(busy === 0, "R4 busy single", {31'b0, busy}, 0);
    chk(tx_a_word === 32'hFF, "R6 tx_a_word code", tx_a_word, 32'hFF);
    foreach (vals[i]) begin
      wr(1, 32'(vals[i]));
      rd(1, mu_e(s16(vals[i], 16)), "R6 mu L16");
    end
    set_ctrl(32, 0, 1);
    wr(1, 32'h1234_5678); rd(1, mu_e(s16(32'h1234_5678, 32)), "R6 mu L32");
    wr(1, 32'h8000_0000); rd(1, mu_e(s16(32'h8000_0000, 32)), "R6 mu L32 min");
    set_ctrl(8, 0, 1);
    wr(1, 32'hFFFF_FF7F); rd(1, mu_e(s16(32'h7F, 8)), "R6 mu L8");

    // R7 A-law compression
    set_ctrl(16, 0, 2);
    wr(1, 0);
    chk(busy === 1, "R4 busy A-law", {31'b0, busy}, 1);
    rd(1, 32'h0000_00D5, "R7 A zero");
    foreach (vals[i]) begin
      wr(1, 32'(vals[i]));
      rd(1, a_e(s16(vals[i], 16)), "R7 A L16");
    end
    set_ctrl(32, 0, 2);
    wr(1, 32'h9876_5432); rd(1, a_e(s16(32'h9876_5432, 32)), "R7 A L32");

    // R8/R9 expansion at several word lengths
    foreach (lens[j]) begin
      set_ctrl(lens[j], 0, 1);
      foreach (codes[i]) begin
        wr(2, 32'(codes[i]));
        rd(2, scale(mu_d(codes[i]), lens[j]), "R8 mu expand");
      end
      set_ctrl(lens[j], 0, 2);
      foreach (codes[i]) begin
        wr(2, 32'(codes[i]));
        rd(2, scale(a_d(codes[i]), lens[j]), "R9 A expand");
      end
    end

    // R10 formatting with companding off
    set_ctrl(12, 0, 0);
    rx_b_load = 1; rx_b_word = 32'hABCD_E9A5; @(posedge clk); #1 rx_b_load = 0;
    rd(4, 32'h0000_09A5, "R10 zero fill B");
    rx_a_load = 1; rx_a_word = 32'h1234_5567; @(posedge clk); #1 rx_a_load = 0;
    rd(2, 32'h0000_0567, "R10 zero fill A");
    set_ctrl(12, 1, 0);
    rx_b_load = 1; rx_b_word = 32'hABCD_E9A5; @(posedge clk); #1 rx_b_load = 0;
    rd(4, fmt(32'hABCD_E9A5, 12, 1), "R10 sign ext B");
    rx_a_load = 1; rx_a_word = 32'h0000_0567; @(posedge clk); #1 rx_a_load = 0;
    rd(2, 32'h0000_0567, "R10 sign ext positive");
    wr(0, 32'h0000_0004);
    rx_b_load = 1; rx_b_word = 32'h0000_0005; @(posedge clk); #1 rx_b_load = 0;
    rd(4, 32'hFFFF_FFFD, "R3 short length clamps to 3");

    // R11 serial loads with companding on
    set_ctrl(16, 1, 1);
    rx_a_load = 1; rx_a_word = 32'hFFFF_FF2A; @(posedge clk); #1 rx_a_load = 0;
    rd(2, scale(mu_d('h2A), 16), "R11 A expands on load");
    rx_b_load = 1; rx_b_word = 32'h0001_802A; @(posedge clk); #1 rx_b_load = 0;
    rd(4, fmt(32'h0001_802A, 16, 1), "R11 B not expanded");

    // R12 priorities
    reg_wr = 1; reg_addr = 4; reg_wdata = 32'h5555_AAAA;
    rx_b_load = 1; rx_b_word = 32'h1111_1111;
    @(posedge clk); #1 reg_wr = 0; rx_b_load = 0;
    rd(4, 32'h5555_AAAA, "R12 write beats load");
    wr(2, 32'h0000_0033);
    rx_a_load = 1; rx_a_word = 32'h0000_0077; @(posedge clk); #1 rx_a_load = 0;
    rd(2, scale(mu_d('h33), 16), "R12 conversion beats load");

    // R5 write held off during busy
    wr(1, 32'h0000_0400);
    reg_wr = 1; reg_addr = 3; reg_wdata = 32'h0BAD_F00D; #0.5;
    chk(reg_stall === 1, "R5 write stalled", {31'b0, reg_stall}, 1);
    chk(tx_b_word === 32'hCAFE_0042, "R5 write not yet done", tx_b_word, 32'hCAFE_0042);
    wr(3, 32'h0BAD_F00D);
    rd(3, 32'h0BAD_F00D, "R5 held write lands");
    rd(1, mu_e(s16(32'h400, 16)), "R5 conversion kept");

    repeat (2) @(posedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule